// File: doc/BRIEF.md
# SDRAM Serial-Presence-Detect Image Builder

This block turns a requested memory type and a module capacity in megabytes into a 256-byte serial-presence-detect image held in an on-chip byte memory. A one-cycle start pulse launches the job. The block rounds the capacity down to a power of two and checks it against the per-bank size window of the type. If the capacity is too small for the requested type, the block moves to a smaller type. It then spreads the capacity over up to eight banks, one step per cycle. A single bank is split into two when the window allows it.

After that the block writes the whole image one byte per cycle. Bytes that have no assigned value are written as zero. A second pass over the low bytes forms an 8-bit checksum, which is stored in the checksum byte. When done rises, the image can be read through a registered address/data port. Status flags report a rejected request, a capacity that was rounded, a type that was moved, and a capacity that could not be covered.

Top module: `spd_image_gen`

## Requirements
- R1: After reset, busy, done and all five status flags are 0.
- R2: mem_type encoding is 1 = SDR, 2 = DDR, 3 = DDR2. Code 0 sets err_type and done, and leaves the stored image untouched.
- R3: A valid type with size_mb below 4 sets err_small and done, leaves the other flags clear, and leaves the image untouched.
- R4: The capacity is taken as 2^m, where m is the index of the highest set bit of size_mb. warn_round is set when any lower bit was set.
- R5: The per-bank log2 window is 2..9 for SDR, 5..12 for DDR and 7..14 for DDR2. If m is below the minimum of the requested type, the type becomes DDR when m >= 5 and SDR otherwise, and type_adjusted is set.
- R6: Starting from one bank of 2^m, the bank size is halved and one bank is added while the bank log2 exceeds the type maximum and fewer than 8 banks exist. cap_truncated is set when banks x bank size is below 2^m.
- R7: If exactly one bank remains and its log2 exceeds the type minimum, it becomes two banks of half size.
- R8: Let d = 2^(bank log2 - 2), kept to 16 bits. Byte 31 holds (d & 0xE0) | ((d >> 8) & 0x1F) for DDR2, (d & 0xF8) | ((d >> 8) & 0x07) for DDR, and d & 0xFF for SDR.
- R9: The image holds byte 0 = 128 and byte 1 = 8. Byte 2 holds the type code of the final type (SDR 4, DDR 7, DDR2 8). Byte 5 holds banks - 1 for DDR2 and banks otherwise.
- R9 (continued): The fixed bytes are 3 = 13, 4 = 10, 6 = 64, 8 = 4, 9 = 0x25, 10 = 1, 12 = 0x82, 13 = 8, 16 = 12, 17 = 4, 18 = 12, 20 = 2, 23 = 0x12, 27 = 20, 28 = 15, 29 = 20, 30 = 45, 32 = 20, 33 = 8, 34 = 20 and 35 = 8. Bytes 15 and 19 are 0 for DDR2 and 1 otherwise. All other bytes below 256, except 63, are 0.
- R10: Byte 63 equals the sum of bytes 0 through 62, modulo 256.
- R11: busy and done are never high together. A start pulse while busy is ignored. Once set, done stays high until the next accepted start, and an accepted start raises busy and clears done on the next cycle.
- R12: rd_data shows the byte at rd_addr one clock edge after rd_addr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to build an image |
| mem_type | input | 2 | Requested memory type (0 invalid, 1 SDR, 2 DDR, 3 DDR2) |
| size_mb | input | SIZE_W | Module capacity in megabytes |
| rd_addr | input | AW | Image byte address for reading |
| rd_data | output | 8 | Image byte, registered |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job finished; flags valid |
| err_type | output | 1 | Invalid type code rejected |
| err_small | output | 1 | Capacity below 4 MB rejected |
| warn_round | output | 1 | Capacity was rounded down to a power of two |
| type_adjusted | output | 1 | Requested type replaced by a smaller one |
| cap_truncated | output | 1 | Eight banks could not cover the capacity |

## Verification
Each type is driven with capacities that sit exactly at its minimum, between its limits (where the split into two banks applies), and above its maximum. This separates the no-split, split and multi-bank paths. Capacities that are not powers of two, capacities below a type's minimum on both sides of 32 MB, and capacities large enough to hit the eight-bank cap separate rounding, type moving and truncation. The density values are chosen so that the high bits of d land in the packed byte for DDR and DDR2 but drop out for SDR. Rejected requests, a start issued while busy, and the read latency are covered by directed tests that re-read image bytes written by an earlier job.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [1:0] {
    MK_NONE = 2'd0,
    MK_SDR  = 2'd1,
    MK_DDR  = 2'd2,
    MK_DDR2 = 2'd3
  } mem_kind_e;

  function automatic int unsigned kind_lo(mem_kind_e k);
    case (k)
      MK_DDR:  return 5;
      MK_DDR2: return 7;
      default: return 2;
    endcase
  endfunction

  function automatic int unsigned kind_hi(mem_kind_e k);
    case (k)
      MK_DDR:  return 12;
      MK_DDR2: return 14;
      default: return 9;
    endcase
  endfunction

  function automatic logic [7:0] kind_code(mem_kind_e k);
    case (k)
      MK_DDR:  return 8'd7;
      MK_DDR2: return 8'd8;
      default: return 8'd4;
    endcase
  endfunction

  function automatic logic [7:0] pack_density(mem_kind_e k, logic [15:0] d);
    case (k)
      MK_DDR2: return (d[7:0] & 8'hE0) | {3'b000, d[12:8]};
      MK_DDR:  return (d[7:0] & 8'hF8) | {5'b00000, d[10:8]};
      default: return d[7:0];
    endcase
  endfunction

endpackage

// File: rtl/spd_geom.sv
module spd_geom
  import spd_pkg::*;
#(
  parameter int SIZE_W    = 20,
  parameter int MAX_BANKS = 8,
  localparam int LOG_W    = $clog2(SIZE_W) + 1,
  localparam int BANK_W   = $clog2(MAX_BANKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  mem_kind_e         kind_in,
  input  logic [SIZE_W-1:0] size_in,
  output logic              ready,
  output logic              bad_kind,
  output logic              too_small,
  output logic              not_pow2,
  output logic              kind_moved,
  output logic              short_cap,
  output mem_kind_e         kind_out,
  output logic [BANK_W-1:0] banks,
  output logic [LOG_W-1:0]  bank_log2
);

  localparam int CAP_W = SIZE_W + BANK_W;

  logic [LOG_W-1:0]  msb;
  logic [SIZE_W-1:0] pow2_val;
  logic [SIZE_W-1:0] pow2_q;
  logic [CAP_W-1:0]  cap;
  logic              looping;

  always_comb begin
    msb = '0;
    for (int i = 0; i < SIZE_W; i++)
      if (size_in[i]) msb = LOG_W'(i);
  end

  assign pow2_val = SIZE_W'(1) << msb;
  assign cap      = CAP_W'(banks) << bank_log2;

  always_ff @(posedge clk) begin
    if (rst) begin
      looping    <= 1'b0;
      ready      <= 1'b0;
      bad_kind   <= 1'b0;
      too_small  <= 1'b0;
      not_pow2   <= 1'b0;
      kind_moved <= 1'b0;
      short_cap  <= 1'b0;
      kind_out   <= MK_SDR;
      banks      <= '0;
      bank_log2  <= '0;
      pow2_q     <= '0;
    end else begin
      ready <= 1'b0;
      if (!looping && go) begin
        bad_kind   <= (kind_in == MK_NONE);
        too_small  <= (kind_in != MK_NONE) && (size_in < SIZE_W'(4));
        not_pow2   <= 1'b0;
        kind_moved <= 1'b0;
        short_cap  <= 1'b0;
        banks      <= BANK_W'(1);
        bank_log2  <= msb;
        if (kind_in == MK_NONE || size_in < SIZE_W'(4)) begin
          ready <= 1'b1;
        end else begin
          not_pow2 <= (size_in != pow2_val);
          pow2_q   <= pow2_val;
          if (msb < LOG_W'(kind_lo(kind_in))) begin
            kind_moved <= 1'b1;
            kind_out   <= (msb >= LOG_W'(5)) ? MK_DDR : MK_SDR;
          end else begin
            kind_out <= kind_in;
          end
          looping <= 1'b1;
        end
      end else if (looping) begin
        if (bank_log2 > LOG_W'(kind_hi(kind_out)) && banks < BANK_W'(MAX_BANKS)) begin
          bank_log2 <= bank_log2 - LOG_W'(1);
          banks     <= banks + BANK_W'(1);
        end else begin
          looping   <= 1'b0;
          ready     <= 1'b1;
          short_cap <= cap < CAP_W'(pow2_q);
          if (banks == BANK_W'(1) && bank_log2 > LOG_W'(kind_lo(kind_out))) begin
            banks     <= BANK_W'(2);
            bank_log2 <= bank_log2 - LOG_W'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/spd_byte_rom.sv
module spd_byte_rom
  import spd_pkg::*;
#(
  parameter int AW     = 8,
  parameter int BANK_W = 4
) (
  input  logic [AW-1:0]     addr,
  input  mem_kind_e         kind,
  input  logic [BANK_W-1:0] banks,
  input  logic [7:0]        density,
  output logic [7:0]        byte_o
);

  logic       is_ddr2;
  logic [7:0] bank_byte;

  assign is_ddr2   = (kind == MK_DDR2);
  assign bank_byte = is_ddr2 ? (8'(banks) - 8'd1) : 8'(banks);

  always_comb begin
    case (32'(addr))
      0:  byte_o = 8'd128;
      1:  byte_o = 8'd8;
      2:  byte_o = kind_code(kind);
      3:  byte_o = 8'd13;
      4:  byte_o = 8'd10;
      5:  byte_o = bank_byte;
      6:  byte_o = 8'd64;
      8:  byte_o = 8'd4;
      9:  byte_o = 8'h25;
      10: byte_o = 8'd1;
      12: byte_o = 8'h82;
      13: byte_o = 8'd8;
      15: byte_o = is_ddr2 ? 8'd0 : 8'd1;
      16: byte_o = 8'd12;
      17: byte_o = 8'd4;
      18: byte_o = 8'd12;
      19: byte_o = is_ddr2 ? 8'd0 : 8'd1;
      20: byte_o = 8'd2;
      23: byte_o = 8'h12;
      27: byte_o = 8'd20;
      28: byte_o = 8'd15;
      29: byte_o = 8'd20;
      30: byte_o = 8'd45;
      31: byte_o = density;
      32: byte_o = 8'd20;
      33: byte_o = 8'd8;
      34: byte_o = 8'd20;
      35: byte_o = 8'd8;
      default: byte_o = 8'd0;
    endcase
  end

endmodule

// File: rtl/spd_image_ram.sv
module spd_image_ram #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/spd_image_gen.sv
module spd_image_gen
  import spd_pkg::*;
#(
  parameter int SIZE_W    = 20,
  parameter int MAX_BANKS = 8,
  parameter int AW        = 8,
  parameter int CK_POS    = 63
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        mem_type,
  input  logic [SIZE_W-1:0] size_mb,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              done,
  output logic              err_type,
  output logic              err_small,
  output logic              warn_round,
  output logic              type_adjusted,
  output logic              cap_truncated
);

  localparam int LOG_W  = $clog2(SIZE_W) + 1;
  localparam int BANK_W = $clog2(MAX_BANKS + 1);
  localparam logic [AW-1:0] CK_ADDR  = AW'(CK_POS);
  localparam logic [AW-1:0] LAST_ADR = {AW{1'b1}};

  typedef enum logic [2:0] {
    S_IDLE, S_PLAN, S_FILL, S_SUM, S_CKWR
  } step_e;

  step_e             st;
  logic              go;
  logic              g_ready, g_bad, g_small, g_round, g_moved, g_short;
  mem_kind_e         g_kind;
  logic [BANK_W-1:0] g_banks;
  logic [LOG_W-1:0]  g_log2;
  logic [15:0]       dens_raw;
  logic [7:0]        dens_byte;
  logic [7:0]        rom_byte;
  logic [AW-1:0]     cnt;
  logic [7:0]        acc;
  logic              pend;
  logic              a_we;
  logic [AW-1:0]     a_addr;
  logic [7:0]        a_wdata, a_rdata;

  assign go = start && (st == S_IDLE);

  spd_geom #(.SIZE_W(SIZE_W), .MAX_BANKS(MAX_BANKS)) geom_i (
    .clk(clk), .rst(rst), .go(go),
    .kind_in(mem_kind_e'(mem_type)), .size_in(size_mb),
    .ready(g_ready), .bad_kind(g_bad), .too_small(g_small),
    .not_pow2(g_round), .kind_moved(g_moved), .short_cap(g_short),
    .kind_out(g_kind), .banks(g_banks), .bank_log2(g_log2)
  );

  assign dens_raw  = 16'd1 << (g_log2 - LOG_W'(2));
  assign dens_byte = pack_density(g_kind, dens_raw);

  spd_byte_rom #(.AW(AW), .BANK_W(BANK_W)) rom_i (
    .addr(cnt), .kind(g_kind), .banks(g_banks),
    .density(dens_byte), .byte_o(rom_byte)
  );

  assign a_we    = (st == S_FILL) || (st == S_CKWR);
  assign a_addr  = (st == S_CKWR) ? CK_ADDR : cnt;
  assign a_wdata = (st == S_CKWR) ? acc : rom_byte;

  spd_image_ram #(.AW(AW), .DW(8)) ram_i (
    .clk(clk), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .b_addr(rd_addr), .b_rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      busy          <= 1'b0;
      done          <= 1'b0;
      err_type      <= 1'b0;
      err_small     <= 1'b0;
      warn_round    <= 1'b0;
      type_adjusted <= 1'b0;
      cap_truncated <= 1'b0;
      cnt           <= '0;
      acc           <= '0;
      pend          <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          busy          <= 1'b1;
          done          <= 1'b0;
          err_type      <= 1'b0;
          err_small     <= 1'b0;
          warn_round    <= 1'b0;
          type_adjusted <= 1'b0;
          cap_truncated <= 1'b0;
          st            <= S_PLAN;
        end
        S_PLAN: if (g_ready) begin
          err_type      <= g_bad;
          err_small     <= g_small;
          warn_round    <= g_round;
          type_adjusted <= g_moved;
          cap_truncated <= g_short;
          cnt           <= '0;
          if (g_bad || g_small) begin
            busy <= 1'b0;
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            st <= S_FILL;
          end
        end
        S_FILL: begin
          cnt <= cnt + AW'(1);
          if (cnt == LAST_ADR) begin
            acc  <= '0;
            pend <= 1'b0;
            st   <= S_SUM;
          end
        end
        S_SUM: begin
          pend <= (cnt < CK_ADDR);
          if (pend) acc <= acc + a_rdata;
          cnt <= cnt + AW'(1);
          if (cnt == CK_ADDR) st <= S_CKWR;
        end
        S_CKWR: begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spd_image_gen_chk.sv
module spd_image_gen_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic err_type,
  input logic err_small,
  input logic warn_round,
  input logic type_adjusted,
  input logic cap_truncated
);

  p_busy_done_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  p_done_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  p_accept_r11: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !done));

  p_small_alone_r3: assert property (@(posedge clk) disable iff (rst)
    err_small |-> (!err_type && !type_adjusted && !cap_truncated && !warn_round));

  p_type_err_done_r2: assert property (@(posedge clk) disable iff (rst)
    err_type |-> done);

  p_round_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable(warn_round));

endmodule

bind spd_image_gen spd_image_gen_chk chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .err_type(err_type), .err_small(err_small), .warn_round(warn_round),
  .type_adjusted(type_adjusted), .cap_truncated(cap_truncated)
);

// File: tb/spd_image_gen_tb.sv
module spd_image_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  mem_type = 2'd0;
  logic [19:0] size_mb = '0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic busy, done, err_type, err_small, warn_round, type_adjusted, cap_truncated;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spd_image_gen dut_i (
    .clk(clk), .rst(rst), .start(start), .mem_type(mem_type), .size_mb(size_mb),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
    .err_type(err_type), .err_small(err_small), .warn_round(warn_round),
    .type_adjusted(type_adjusted), .cap_truncated(cap_truncated)
  );

  // {type, size, flags{type,small,round,adj,trunc}, byte2, byte5, byte31}
  localparam logic [50:0] VECS [0:NV-1] = '{
    {2'd1, 20'd64,     5'b00000, 8'd4, 8'd2, 8'd8},
    {2'd2, 20'd1024,   5'b00000, 8'd7, 8'd2, 8'd128},
    {2'd3, 20'd8192,   5'b00000, 8'd8, 8'd1, 8'd4},
    {2'd3, 20'd100,    5'b00110, 8'd7, 8'd2, 8'd8},
    {2'd2, 20'd16,     5'b00010, 8'd4, 8'd2, 8'd2},
    {2'd1, 20'd4,      5'b00000, 8'd4, 8'd1, 8'd1},
    {2'd1, 20'd4096,   5'b00001, 8'd4, 8'd4, 8'd128},
    {2'd1, 20'd262144, 5'b00001, 8'd4, 8'd8, 8'd0},
    {2'd3, 20'd32768,  5'b00000, 8'd8, 8'd1, 8'd16},
    {2'd2, 20'd32,     5'b00000, 8'd7, 8'd1, 8'd8},
    {2'd2, 20'd8192,   5'b00000, 8'd7, 8'd2, 8'd4},
    {2'd2, 20'd5000,   5'b00100, 8'd7, 8'd2, 8'd2},
    {2'd3, 20'd48,     5'b00110, 8'd7, 8'd1, 8'd8},
    {2'd3, 20'hFFFFF,  5'b00101, 8'd8, 8'd5, 8'd16}
  };

  function automatic logic [7:0] fixed_byte(int a, logic [7:0] b2, logic [7:0] b5, logic [7:0] b31);
    logic [7:0] alt;
    alt = (b2 == 8'd8) ? 8'd0 : 8'd1;
    case (a)
      0: return 8'd128;   1: return 8'd8;     2: return b2;      3: return 8'd13;
      4: return 8'd10;    5: return b5;       6: return 8'd64;   8: return 8'd4;
      9: return 8'h25;    10: return 8'd1;    12: return 8'h82;  13: return 8'd8;
      15: return alt;     16: return 8'd12;   17: return 8'd4;   18: return 8'd12;
      19: return alt;     20: return 8'd2;    23: return 8'h12;  27: return 8'd20;
      28: return 8'd15;   29: return 8'd20;   30: return 8'd45;  31: return b31;
      32: return 8'd20;   33: return 8'd8;    34: return 8'd20;  35: return 8'd8;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] exp_byte(int a, logic [7:0] b2, logic [7:0] b5, logic [7:0] b31);
    logic [7:0] s;
    if (a != 63) return fixed_byte(a, b2, b5, b31);
    s = 8'd0;
    for (int k = 0; k < 63; k++) s = s + fixed_byte(k, b2, b5, b31);
    return s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic read_byte(int a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = 8'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) return;
    end
    check("R11 done timeout", 32'(done), 32'd1);
  endtask

  task automatic run(logic [1:0] ty, logic [19:0] sz);
    @(negedge clk);
    mem_type = ty;
    size_mb  = sz;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  function automatic logic [4:0] flags_now();
    return {err_type, err_small, warn_round, type_adjusted, cap_truncated};
  endfunction

  task automatic check_image(string tag, logic [7:0] b2, logic [7:0] b5, logic [7:0] b31);
    logic [7:0] v;
    for (int a = 0; a < 256; a++) begin
      read_byte(a, v);
      if (a == 63) check({tag, " R10 checksum"}, 32'(v), 32'(exp_byte(a, b2, b5, b31)));
      else if (a == 31) check({tag, " R8 density"}, 32'(v), 32'(b31));
      else if (a == 5 || a == 2) check({tag, " R9 bank/type byte"}, 32'(v), 32'(exp_byte(a, b2, b5, b31)));
      else check({tag, " R9 image byte"}, 32'(v), 32'(exp_byte(a, b2, b5, b31)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 flags", 32'(flags_now()), 32'd0);

    // table walk: R4 R5 R6 R7 R8 R9 R10
    for (int n = 0; n < NV; n++) begin
      run(VECS[n][50:49], VECS[n][48:29]);
      check($sformatf("vec%0d R4/R5/R6 flags", n), 32'(flags_now()), 32'(VECS[n][28:24]));
      check($sformatf("vec%0d R11 busy low", n), 32'(busy), 32'd0);
      check_image($sformatf("vec%0d", n), VECS[n][23:16], VECS[n][15:8], VECS[n][7:0]);
    end
    // last image is DDR2, byte2 = 8

    // R2 invalid type: flag, done, image untouched
    run(2'd0, 20'd64);
    check("R2 flags", 32'(flags_now()), 32'b10000);
    check("R2 done", 32'(done), 32'd1);
    read_byte(2, v);
    check("R2 image untouched", 32'(v), 32'd8);

    // R3 too small
    run(2'd1, 20'd3);
    check("R3 flags size3", 32'(flags_now()), 32'b01000);
    read_byte(31, v);
    check("R3 image untouched", 32'(v), 32'd16);
    run(2'd2, 20'd0);
    check("R3 flags size0", 32'(flags_now()), 32'b01000);

    // R11 start while busy is ignored; done holds
    @(negedge clk);
    mem_type = 2'd3; size_mb = 20'd8192; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11 busy after start", 32'(busy), 32'd1);
    check("R11 done cleared", 32'(done), 32'd0);
    repeat (4) @(negedge clk);
    mem_type = 2'd1; size_mb = 20'd64; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (10) @(negedge clk);
    check("R11 done held", 32'(done), 32'd1);
    read_byte(2, v);
    check("R11 second start ignored", 32'(v), 32'd8);

    // R12 read latency
    @(negedge clk);
    rd_addr = 8'd0;
    @(negedge clk);
    check("R12 data after edge", 32'(rd_data), 32'd128);
    rd_addr = 8'd2;
    #1;
    check("R12 data holds before edge", 32'(rd_data), 32'd128);
    @(negedge clk);
    check("R12 new data", 32'(rd_data), 32'd8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule